// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Stall Unit

This block resolves read-after-write data hazards in a five-stage in-order pipeline. Its forwarding half looks at the two source register numbers of the instruction now in the execute stage. It compares each of them against the destination registers of the two older instructions that sit in the memory-access stage and the write-back stage. For each ALU operand it produces a 2-bit multiplexer select that picks the register-file value, the memory-stage ALU result or the write-back value.

Its stall half looks at the instruction being decoded. When the instruction in execute is a load whose destination matches either decode source, the loaded value cannot be produced in time. The unit then freezes the program counter and the fetch/decode pipeline register, and zeroes the control word passed into execute so that a bubble moves down the pipe. One cycle later the load has reached write-back, and the forwarding half delivers its result from there.

The block is purely combinational. Every output follows its inputs within the same cycle.

Top module: `hazard_fwd_unit`

## Requirements
- R1: Each operand select is 2'b00 (register file) when no producing stage qualifies. The value 2'b11 is never driven.
- R2: An operand select is 2'b10 when the memory-stage destination equals that operand's source, the memory-stage write flag is 1 and the destination is not register 0.
- R3: An operand select is 2'b01 when the write-back destination equals that operand's source, the write-back write flag is 1, the destination is not register 0, and R2 does not apply.
- R4: When both the memory stage and the write-back stage qualify for the same operand, the select is 2'b10, because the younger result wins.
- R5: A stage whose write flag is 0 is never forwarded from, even when its destination matches.
- R6: Register 0 is never forwarded. A source of 0 always yields select 2'b00.
- R7: Operand A follows only the A source and operand B follows only the B source. The two selects are independent.
- R8: When the execute-stage load flag is 1 and the execute-stage load destination equals the decode A source or the decode B source, pc_write_en and ifid_write_en are 0 and ctrl_zero is 1. Register 0 is included in this comparison.
- R9: When the load flag is 0, or neither decode source matches, pc_write_en and ifid_write_en are 1 and ctrl_zero is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | REG_ADDR_W | First source register of the instruction in execute |
| ex_src_b | input | REG_ADDR_W | Second source register of the instruction in execute |
| mem_dst | input | REG_ADDR_W | Destination register held in the execute/memory register |
| mem_wr_en | input | 1 | Register-write flag held in the execute/memory register |
| wb_dst | input | REG_ADDR_W | Destination register held in the memory/write-back register |
| wb_wr_en | input | 1 | Register-write flag held in the memory/write-back register |
| id_src_a | input | REG_ADDR_W | First source register of the instruction in decode |
| id_src_b | input | REG_ADDR_W | Second source register of the instruction in decode |
| ex_ld_dst | input | REG_ADDR_W | Load destination register held in the decode/execute register |
| ex_is_load | input | 1 | Memory-read flag held in the decode/execute register |
| fwd_sel_a | output | 2 | Operand A select: 00 register file, 10 memory stage, 01 write-back |
| fwd_sel_b | output | 2 | Operand B select, same encoding |
| pc_write_en | output | 1 | Program counter update enable; 0 during a stall |
| ifid_write_en | output | 1 | Fetch/decode register load enable; 0 during a stall |
| ctrl_zero | output | 1 | Forces the control word into execute to zero; 1 during a stall |

## Verification
All results are combinational, so each one is due in the same cycle that its inputs are applied, with no register between them. The bench drives a new input vector just after a rising edge and compares the outputs at the following falling edge. This leaves half a period for the outputs to settle and keeps every comparison clear of the edge at which inputs change. With a 3-bit register number, both forwarding operands are swept over every source, destination and write-flag combination, and the stall detector is swept over every pair of decode sources, every load destination and both load-flag values.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  typedef enum logic [1:0] {
    FWD_FROM_RF  = 2'b00,
    FWD_FROM_WB  = 2'b01,
    FWD_FROM_MEM = 2'b10
  } fwd_sel_e;

  localparam int unsigned NUM_OPERANDS = 2;

endpackage

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel
  import hzd_pkg::*;
#(
  parameter int unsigned REG_ADDR_W = 5
) (
  input  logic [REG_ADDR_W-1:0] src,
  input  logic [REG_ADDR_W-1:0] mem_dst,
  input  logic                  mem_wr_en,
  input  logic [REG_ADDR_W-1:0] wb_dst,
  input  logic                  wb_wr_en,
  output fwd_sel_e              sel
);

  localparam logic [REG_ADDR_W-1:0] ZERO_REG = '0;

  logic mem_hit;
  logic wb_hit;

  // A stage qualifies only if it writes, targets a real register and matches.
  assign mem_hit = mem_wr_en && (mem_dst != ZERO_REG) && (mem_dst == src);
  assign wb_hit  = wb_wr_en  && (wb_dst  != ZERO_REG) && (wb_dst  == src);

  // Younger (memory-stage) result takes priority.
  always_comb begin
    if (mem_hit)     sel = FWD_FROM_MEM;
    else if (wb_hit) sel = FWD_FROM_WB;
    else             sel = FWD_FROM_RF;
  end

endmodule

// File: rtl/load_use_detect.sv
module load_use_detect #(
  parameter int unsigned REG_ADDR_W = 5
) (
  input  logic [REG_ADDR_W-1:0] id_src_a,
  input  logic [REG_ADDR_W-1:0] id_src_b,
  input  logic [REG_ADDR_W-1:0] ex_ld_dst,
  input  logic                  ex_is_load,
  output logic                  stall
);

  logic hit_a;
  logic hit_b;

  assign hit_a = (ex_ld_dst == id_src_a);
  assign hit_b = (ex_ld_dst == id_src_b);
  assign stall = ex_is_load && (hit_a || hit_b);

endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit
  import hzd_pkg::*;
#(
  parameter int unsigned REG_ADDR_W = 5
) (
  input  logic [REG_ADDR_W-1:0] ex_src_a,
  input  logic [REG_ADDR_W-1:0] ex_src_b,
  input  logic [REG_ADDR_W-1:0] mem_dst,
  input  logic                  mem_wr_en,
  input  logic [REG_ADDR_W-1:0] wb_dst,
  input  logic                  wb_wr_en,
  input  logic [REG_ADDR_W-1:0] id_src_a,
  input  logic [REG_ADDR_W-1:0] id_src_b,
  input  logic [REG_ADDR_W-1:0] ex_ld_dst,
  input  logic                  ex_is_load,
  output logic [1:0]            fwd_sel_a,
  output logic [1:0]            fwd_sel_b,
  output logic                  pc_write_en,
  output logic                  ifid_write_en,
  output logic                  ctrl_zero
);

  logic [NUM_OPERANDS-1:0][REG_ADDR_W-1:0] src_vec;
  fwd_sel_e                                sel_vec [NUM_OPERANDS];
  logic                                    stall;

  assign src_vec[0] = ex_src_a;
  assign src_vec[1] = ex_src_b;

  // One identical selector per ALU operand.
  for (genvar g = 0; g < NUM_OPERANDS; g++) begin : g_opnd
    fwd_operand_sel #(
      .REG_ADDR_W(REG_ADDR_W)
    ) i_sel (
      .src       (src_vec[g]),
      .mem_dst   (mem_dst),
      .mem_wr_en (mem_wr_en),
      .wb_dst    (wb_dst),
      .wb_wr_en  (wb_wr_en),
      .sel       (sel_vec[g])
    );
  end

  assign fwd_sel_a = sel_vec[0];
  assign fwd_sel_b = sel_vec[1];

  load_use_detect #(
    .REG_ADDR_W(REG_ADDR_W)
  ) i_ldu (
    .id_src_a   (id_src_a),
    .id_src_b   (id_src_b),
    .ex_ld_dst  (ex_ld_dst),
    .ex_is_load (ex_is_load),
    .stall      (stall)
  );

  // A stall freezes fetch and decode and injects a bubble into execute.
  assign pc_write_en   = !stall;
  assign ifid_write_en = !stall;
  assign ctrl_zero     = stall;

endmodule

// File: rtl/hazard_fwd_unit_chk.sv
module hazard_fwd_unit_chk #(
  parameter int unsigned REG_ADDR_W = 5
) (
  input logic [REG_ADDR_W-1:0] ex_src_a,
  input logic [REG_ADDR_W-1:0] ex_src_b,
  input logic [REG_ADDR_W-1:0] mem_dst,
  input logic                  mem_wr_en,
  input logic [REG_ADDR_W-1:0] wb_dst,
  input logic                  wb_wr_en,
  input logic [REG_ADDR_W-1:0] id_src_a,
  input logic [REG_ADDR_W-1:0] id_src_b,
  input logic [REG_ADDR_W-1:0] ex_ld_dst,
  input logic                  ex_is_load,
  input logic [1:0]            fwd_sel_a,
  input logic [1:0]            fwd_sel_b,
  input logic                  pc_write_en,
  input logic                  ifid_write_en,
  input logic                  ctrl_zero
);

  always_comb begin
    assert_sel_legal_R1: assert (fwd_sel_a != 2'b11 && fwd_sel_b != 2'b11)
      else $error("illegal select");
    assert_mem_wins_R4: assert (!(mem_wr_en && mem_dst != '0 && mem_dst == ex_src_a)
                                || fwd_sel_a == 2'b10)
      else $error("memory-stage match not forwarded");
    assert_no_fwd_wr_off_R5: assert ((mem_wr_en || wb_wr_en)
                                     || (fwd_sel_a == 2'b00 && fwd_sel_b == 2'b00))
      else $error("forward with no writer");
    assert_r0_never_fwd_R6: assert ((ex_src_a != '0 || fwd_sel_a == 2'b00)
                                    && (ex_src_b != '0 || fwd_sel_b == 2'b00))
      else $error("register 0 forwarded");
    assert_stall_outputs_agree_R8: assert (pc_write_en == ifid_write_en
                                           && ctrl_zero == !pc_write_en)
      else $error("stall outputs disagree");
    assert_no_stall_without_load_R9: assert (ex_is_load || pc_write_en)
      else $error("stall without load");
  end

endmodule

bind hazard_fwd_unit hazard_fwd_unit_chk #(.REG_ADDR_W(REG_ADDR_W)) i_chk (.*);

// File: tb/test_hazard_fwd_unit.sv
module test_hazard_fwd_unit;

  localparam int unsigned W = 3;
  localparam int unsigned N = 1 << W;

  logic         clk;
  logic [W-1:0] ex_src_a, ex_src_b, mem_dst, wb_dst, id_src_a, id_src_b, ex_ld_dst;
  logic         mem_wr_en, wb_wr_en, ex_is_load;
  logic [1:0]   fwd_sel_a, fwd_sel_b;
  logic         pc_write_en, ifid_write_en, ctrl_zero;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  hazard_fwd_unit #(.REG_ADDR_W(W)) i_hazard_fwd_unit (.*);

  // Expected select from the requirement text (R1..R6).
  function automatic logic [1:0] want_sel(input logic [W-1:0] s, md, input logic mw,
                                          input logic [W-1:0] wd, input logic ww);
    if (mw && md != 0 && md == s)      return 2'b10;
    else if (ww && wd != 0 && wd == s) return 2'b01;
    else                               return 2'b00;
  endfunction

  function automatic string sel_tag(input logic [W-1:0] s, md, input logic mw,
                                    input logic [W-1:0] wd, input logic ww);
    if (s == 0)                                   return "R6";
    if (mw && md == s && ww && wd == s)           return "R4";
    if (mw && md == s)                            return "R2";
    if (ww && wd == s)                            return "R3";
    if (md == s || wd == s)                       return "R5";
    return "R1";
  endfunction

  task automatic check_sel(input string opnd, input logic [1:0] act, input logic [1:0] exp,
                           input string tag);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s/R7 operand %s: actual %b expected %b", tag, opnd, act, exp);
    end
  endtask

  task automatic check_stall(input logic exp_stall, input string tag);
    logic [2:0] act, exp;
    act = {pc_write_en, ifid_write_en, ctrl_zero};
    exp = exp_stall ? 3'b001 : 3'b110;
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s stall outputs: actual %b expected %b", tag, act, exp);
    end
  endtask

  initial begin
    ex_src_a = '0; ex_src_b = '0; mem_dst = '0; wb_dst = '0;
    id_src_a = 3'd1; id_src_b = 3'd2; ex_ld_dst = 3'd3;
    mem_wr_en = 1'b0; wb_wr_en = 1'b0; ex_is_load = 1'b0;
    @(negedge clk);
    // Idle state: nothing forwarded, no stall (R1, R9).
    check_sel("a", fwd_sel_a, 2'b00, "R1");
    check_sel("b", fwd_sel_b, 2'b00, "R1");
    check_stall(1'b0, "R9");

    // Forwarding sweep: both operands independently (R7) over all cases.
    for (int sa = 0; sa < N; sa++)
      for (int sb = 0; sb < N; sb++)
        for (int md = 0; md < N; md++)
          for (int wd = 0; wd < N; wd++)
            for (int fl = 0; fl < 4; fl++) begin
              @(posedge clk);
              ex_src_a  <= W'(sa);
              ex_src_b  <= W'(sb);
              mem_dst   <= W'(md);
              wb_dst    <= W'(wd);
              mem_wr_en <= fl[0];
              wb_wr_en  <= fl[1];
              @(negedge clk);
              check_sel("a", fwd_sel_a,
                        want_sel(W'(sa), W'(md), fl[0], W'(wd), fl[1]),
                        sel_tag(W'(sa), W'(md), fl[0], W'(wd), fl[1]));
              check_sel("b", fwd_sel_b,
                        want_sel(W'(sb), W'(md), fl[0], W'(wd), fl[1]),
                        sel_tag(W'(sb), W'(md), fl[0], W'(wd), fl[1]));
            end

    // Load-use sweep (R8 stall, R9 no stall), register 0 included.
    for (int ia = 0; ia < N; ia++)
      for (int ib = 0; ib < N; ib++)
        for (int ld = 0; ld < N; ld++)
          for (int lf = 0; lf < 2; lf++) begin
            @(posedge clk);
            id_src_a   <= W'(ia);
            id_src_b   <= W'(ib);
            ex_ld_dst  <= W'(ld);
            ex_is_load <= lf[0];
            @(negedge clk);
            if (lf[0] && (ld == ia || ld == ib)) check_stall(1'b1, "R8");
            else                                 check_stall(1'b0, "R9");
          end

    // Stalled pair resumes: load now in write-back, forwarded from there (R3).
    @(posedge clk);
    ex_is_load <= 1'b0; mem_wr_en <= 1'b0; wb_wr_en <= 1'b1;
    wb_dst <= 3'd5; ex_src_a <= 3'd5; ex_src_b <= 3'd5;
    @(negedge clk);
    check_stall(1'b0, "R9");
    check_sel("a", fwd_sel_a, 2'b01, "R3");
    check_sel("b", fwd_sel_b, 2'b01, "R3");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule